// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Peripheral Direction Override

This block is a general-purpose I/O port on a small register bus. Software sets each pin's direction through a direction register and its output level through a data register. It reads the actual pin levels through a read-only input register. The input register always returns the buffered pin state, whatever the pin's direction. On a pin that is driven as an output, software can compare the read level with the driven level to detect an overload or a short circuit.

Attached serial peripherals can take over the direction of their pins. While the SPI is enabled, it supplies the direction of pins 4 to 7 from its own per-pin direction vector. An enabled serial transmit channel forces pin 1 to output. An enabled serial receive channel forces pin 0 to input. When a peripheral is disabled, its pins follow the direction register again. The direction register keeps its contents while it is overridden.

The pin levels pass through a two-flop synchronizer before they can be read. Register reads return data one cycle after the request.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset the direction register and the data register are 0x00. As a result, `pin_oe` and `pin_out` are 0x00 and `bus_rdata` is 0x00.
- R2: The direction register at offset 0x372 can be written at any time and reads back what was written. With no peripheral enabled, `pin_oe[i]` equals direction bit i from the clock edge that completes the write. A bit value of 1 means output and 0 means input.
- R3: The data register at offset 0x370 reads back what was written and drives `pin_out` from the clock edge that completes the write.
- R4: A read of offset 0x371 returns the pin levels as seen on `pin_in`, on input and output pins alike. On an output pin this read value may differ from `pin_out`.
- R5: A write to offset 0x371, or to any offset other than 0x370, 0x371 and 0x372, changes no register. A read of an unmapped offset returns 0x00.
- R6: A read request at clock edge k places its data on `bus_rdata` for the cycle after edge k. In any cycle that follows an edge without a read request, `bus_rdata` is 0x00.
- R7: While `spi_en` is 1, `pin_oe[4+k]` equals `spi_dir[k]` for k = 0..3, whatever the direction register holds.
- R8: While `sci_tx_en` is 1, `pin_oe[1]` is 1, whatever direction bit 1 holds.
- R9: While `sci_rx_en` is 1, `pin_oe[0]` is 0, whatever direction bit 0 holds.
- R10: After a peripheral enable drops, the pins it controlled take their direction from the retained direction register bits again.
- R11: A change on `pin_in` that is presented before clock edge A is returned by reads sampled at edge A+2 and later. Reads sampled at edges A and A+1 still return the previous level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 10 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| spi_en | input | 1 | SPI enabled; SPI owns the direction of pins 4 to 7 |
| spi_dir | input | 4 | SPI direction for pins 4 to 7 (1 = output) |
| sci_tx_en | input | 1 | Serial transmit channel enabled (pin 1 forced to output) |
| sci_rx_en | input | 1 | Serial receive channel enabled (pin 0 forced to input) |
| pin_in | input | 8 | Buffered pin levels |
| pin_out | output | 8 | Data register value driven to the pads |
| pin_oe | output | 8 | Per-pin output enable after override |

## Verification
The hardest situation to reach is an override that hides a direction register value which software changed while the override was active. The register cannot be seen on `pin_oe` until the enable drops, so the bench writes new direction values while the SPI and serial enables are asserted. It reads them back over the bus to confirm they were retained, then drops the enables and checks that `pin_oe` reverts to those bits. The synchronizer delay is exercised by changing `pin_in` at the same moment a three-cycle burst of reads starts, so the old and new levels both appear at the expected edges.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

   // Register selected by the current bus offset
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_DATA = 2'd1,
      SEL_IN   = 2'd2,
      SEL_DIR  = 2'd3
   } reg_sel_e;

   // True when pin index p falls inside the window [lsb, lsb+n)
   function automatic bit pin_in_window(int p, int lsb, int n);
      return (p >= lsb) && (p < lsb + n);
   endfunction

endpackage

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_ovr_sync: STAGES must be at least 2");
   end

   // The flops have no reset: their contents simply follow the pins.
   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) begin
         stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
   import gpio_ovr_pkg::*;
#(
   parameter int                WIDTH    = 8,
   parameter int                ADDR_W   = 10,
   parameter logic [ADDR_W-1:0] OFS_DATA = 'h370,
   parameter logic [ADDR_W-1:0] OFS_IN   = 'h371,
   parameter logic [ADDR_W-1:0] OFS_DIR  = 'h372
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  logic [WIDTH-1:0]  wdata,
   input  logic [WIDTH-1:0]  in_sync,
   output logic [WIDTH-1:0]  rdata,
   output logic [WIDTH-1:0]  dir_q,
   output logic [WIDTH-1:0]  data_q
);

   reg_sel_e         sel;
   logic [WIDTH-1:0] rd_mux;

   always_comb begin
      if (addr == OFS_DATA)     sel = SEL_DATA;
      else if (addr == OFS_IN)  sel = SEL_IN;
      else if (addr == OFS_DIR) sel = SEL_DIR;
      else                      sel = SEL_NONE;
   end

   always_comb begin
      unique case (sel)
         SEL_DATA: rd_mux = data_q;
         SEL_IN:   rd_mux = in_sync;
         SEL_DIR:  rd_mux = dir_q;
         default:  rd_mux = '0;
      endcase
   end

   // Writes to the input register or unmapped offsets fall through untouched.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q  <= '0;
         data_q <= '0;
         rdata  <= '0;
      end else begin
         if (wr && sel == SEL_DIR)  dir_q  <= wdata;
         if (wr && sel == SEL_DATA) data_q <= wdata;
         rdata <= rd ? rd_mux : '0;
      end
   end

endmodule

// File: rtl/gpio_ovr_dirmux.sv
module gpio_ovr_dirmux
   import gpio_ovr_pkg::*;
#(
   parameter int WIDTH   = 8,
   parameter int RX_PIN  = 0,
   parameter int TX_PIN  = 1,
   parameter int SPI_LSB = 4,
   parameter int SPI_N   = 4
) (
   input  logic [WIDTH-1:0] dir_q,
   input  logic             spi_en,
   input  logic [SPI_N-1:0] spi_dir,
   input  logic             tx_en,
   input  logic             rx_en,
   output logic [WIDTH-1:0] oe
);

   // Priority per pin: SPI, then serial channel, then direction register.
   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      localparam bit IS_SPI = pin_in_window(i, SPI_LSB, SPI_N);
      localparam bit IS_TX  = (i == TX_PIN);
      localparam bit IS_RX  = (i == RX_PIN);

      logic ser_oe;

      if (IS_TX) begin : g_tx
         assign ser_oe = tx_en ? 1'b1 : dir_q[i];
      end else if (IS_RX) begin : g_rx
         assign ser_oe = rx_en ? 1'b0 : dir_q[i];
      end else begin : g_plain
         assign ser_oe = dir_q[i];
      end

      if (IS_SPI) begin : g_spi
         assign oe[i] = spi_en ? spi_dir[i-SPI_LSB] : ser_oe;
      end else begin : g_nospi
         assign oe[i] = ser_oe;
      end
   end

endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port #(
   parameter int                WIDTH       = 8,
   parameter int                ADDR_W      = 10,
   parameter logic [ADDR_W-1:0] OFS_DATA    = 'h370,
   parameter logic [ADDR_W-1:0] OFS_IN      = 'h371,
   parameter logic [ADDR_W-1:0] OFS_DIR     = 'h372,
   parameter int                RX_PIN      = 0,
   parameter int                TX_PIN      = 1,
   parameter int                SPI_LSB     = 4,
   parameter int                SPI_N       = 4,
   parameter int                SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic              spi_en,
   input  logic [SPI_N-1:0]  spi_dir,
   input  logic              sci_tx_en,
   input  logic              sci_rx_en,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pin_oe
);

   // Elaboration-time parameter checks
   if (WIDTH < 2 || SPI_N < 1 || SPI_LSB < 0 || SPI_LSB + SPI_N > WIDTH) begin : g_bad_spi
      $error("gpio_ovr_port: SPI window does not fit the port");
   end
   if (RX_PIN < 0 || RX_PIN >= WIDTH || TX_PIN < 0 || TX_PIN >= WIDTH || RX_PIN == TX_PIN) begin : g_bad_ser
      $error("gpio_ovr_port: serial pins must be distinct and inside the port");
   end
   if (OFS_DATA == OFS_IN || OFS_DATA == OFS_DIR || OFS_IN == OFS_DIR) begin : g_bad_ofs
      $error("gpio_ovr_port: register offsets must differ");
   end

   logic [WIDTH-1:0] in_sync;
   logic [WIDTH-1:0] dir_q;

   gpio_ovr_sync #(
      .WIDTH  (WIDTH),
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk (clk),
      .d   (pin_in),
      .q   (in_sync)
   );

   gpio_ovr_regs #(
      .WIDTH    (WIDTH),
      .ADDR_W   (ADDR_W),
      .OFS_DATA (OFS_DATA),
      .OFS_IN   (OFS_IN),
      .OFS_DIR  (OFS_DIR)
   ) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (bus_addr),
      .wr      (bus_wr),
      .rd      (bus_rd),
      .wdata   (bus_wdata),
      .in_sync (in_sync),
      .rdata   (bus_rdata),
      .dir_q   (dir_q),
      .data_q  (pin_out)
   );

   gpio_ovr_dirmux #(
      .WIDTH   (WIDTH),
      .RX_PIN  (RX_PIN),
      .TX_PIN  (TX_PIN),
      .SPI_LSB (SPI_LSB),
      .SPI_N   (SPI_N)
   ) i_dirmux (
      .dir_q   (dir_q),
      .spi_en  (spi_en),
      .spi_dir (spi_dir),
      .tx_en   (sci_tx_en),
      .rx_en   (sci_rx_en),
      .oe      (pin_oe)
   );

endmodule

// File: rtl/gpio_ovr_chk.sv
module gpio_ovr_chk
   import gpio_ovr_pkg::*;
#(
   parameter int                WIDTH       = 8,
   parameter int                ADDR_W      = 10,
   parameter logic [ADDR_W-1:0] OFS_DATA    = 'h370,
   parameter logic [ADDR_W-1:0] OFS_IN      = 'h371,
   parameter logic [ADDR_W-1:0] OFS_DIR     = 'h372,
   parameter int                RX_PIN      = 0,
   parameter int                TX_PIN      = 1,
   parameter int                SPI_LSB     = 4,
   parameter int                SPI_N       = 4,
   parameter int                SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [WIDTH-1:0]  bus_wdata,
   input logic [WIDTH-1:0]  bus_rdata,
   input logic              spi_en,
   input logic [SPI_N-1:0]  spi_dir,
   input logic              sci_tx_en,
   input logic              sci_rx_en,
   input logic [WIDTH-1:0]  pin_in,
   input logic [WIDTH-1:0]  pin_out,
   input logic [WIDTH-1:0]  pin_oe
);

   localparam bit TX_IN_SPI = pin_in_window(TX_PIN, SPI_LSB, SPI_N);
   localparam bit RX_IN_SPI = pin_in_window(RX_PIN, SPI_LSB, SPI_N);

   logic unmapped;
   logic any_ovr;
   assign unmapped = (bus_addr != OFS_DATA) && (bus_addr != OFS_IN) && (bus_addr != OFS_DIR);
   assign any_ovr  = spi_en || sci_tx_en || sci_rx_en;

   // R2
   dir_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_DIR) |=> (any_ovr || pin_oe == $past(bus_wdata)));

   // R3
   data_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_DATA) |=> (pin_out == $past(bus_wdata)));

   // R4
   if (SYNC_STAGES == 2) begin : g_in_chk
      in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && bus_addr == OFS_IN) |=> (bus_rdata == $past(pin_in, 3)));
   end

   // R5
   unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && unmapped) |=> (bus_rdata == '0));

   // R6
   idle_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (bus_rdata == '0));

   // R7
   spi_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi_en |-> (pin_oe[SPI_LSB +: SPI_N] == spi_dir));

   // R8
   tx_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sci_tx_en && !(spi_en && TX_IN_SPI)) |-> pin_oe[TX_PIN]);

   // R9
   rx_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sci_rx_en && !(spi_en && RX_IN_SPI)) |-> !pin_oe[RX_PIN]);

endmodule

bind gpio_ovr_port gpio_ovr_chk #(
   .WIDTH       (WIDTH),
   .ADDR_W      (ADDR_W),
   .OFS_DATA    (OFS_DATA),
   .OFS_IN      (OFS_IN),
   .OFS_DIR     (OFS_DIR),
   .RX_PIN      (RX_PIN),
   .TX_PIN      (TX_PIN),
   .SPI_LSB     (SPI_LSB),
   .SPI_N       (SPI_N),
   .SYNC_STAGES (SYNC_STAGES)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .spi_en    (spi_en),
   .spi_dir   (spi_dir),
   .sci_tx_en (sci_tx_en),
   .sci_rx_en (sci_rx_en),
   .pin_in    (pin_in),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe)
);

// File: tb/test_gpio_ovr_port.sv
`timescale 1ns/1ps
module test_gpio_ovr_port;

   localparam logic [9:0] A_DATA = 10'h370;
   localparam logic [9:0] A_IN   = 10'h371;
   localparam logic [9:0] A_DIR  = 10'h372;
   localparam logic [9:0] A_NONE = 10'h300;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       spi_en = 1'b0;
   logic [3:0] spi_dir = '0;
   logic       sci_tx_en = 1'b0;
   logic       sci_rx_en = 1'b0;
   logic [7:0] pin_in = 8'h00;
   logic [7:0] pin_out;
   logic [7:0] pin_oe;

   int checks = 0;
   int failures = 0;

   logic [7:0] exp_q [$];
   string      tag_q [$];
   logic       rd_seen = 1'b0;

   always #2.5 clk = ~clk;

   gpio_ovr_port i_gpio_ovr_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .spi_en    (spi_en),
      .spi_dir   (spi_dir),
      .sci_tx_en (sci_tx_en),
      .sci_rx_en (sci_rx_en),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe)
   );

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [9:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   // Driver: queues the expected read data, the monitor compares it.
   task automatic bus_read(input logic [9:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   // Monitor: data is registered at the edge that sampled bus_rd.
   always @(posedge clk) rd_seen <= bus_rd;
   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) begin
            checks++; failures++;
            $display("FAIL R6 unexpected read data actual=%02h expected=none", bus_rdata);
         end else begin
            check8(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
         end
      end
   end

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      #(5.0 * 100000);
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      repeat (6) @(negedge clk);
      // R1: reset values observed while reset is held and after release
      check8("R1 pin_oe in reset", pin_oe, 8'h00);
      check8("R1 pin_out in reset", pin_out, 8'h00);
      check8("R1 rdata in reset", bus_rdata, 8'h00);
      rst_n = 1'b1;
      bus_read(A_DIR, 8'h00, "R1 direction reset");
      bus_read(A_DATA, 8'h00, "R1 data reset");

      // R2: direction write and read back
      bus_write(A_DIR, 8'hA5);
      check8("R2 pin_oe follows dir", pin_oe, 8'hA5);
      bus_read(A_DIR, 8'hA5, "R2 direction readback");

      // R3: data register
      bus_write(A_DATA, 8'h3C);
      check8("R3 pin_out", pin_out, 8'h3C);
      bus_read(A_DATA, 8'h3C, "R3 data readback");

      // R4: input register on mixed directions, level differs from driven value
      @(negedge clk); pin_in = 8'h5A;
      repeat (3) @(negedge clk);
      bus_read(A_IN, 8'h5A, "R4 input read 5A");
      @(negedge clk); pin_in = 8'hC3;
      repeat (3) @(negedge clk);
      bus_read(A_IN, 8'hC3, "R4 input read C3 vs driven 3C");

      // R5: writes to input or unmapped offsets change nothing
      bus_write(A_IN, 8'hFF);
      bus_write(A_NONE, 8'h0F);
      bus_read(A_IN, 8'hC3, "R5 input unchanged");
      bus_read(A_DIR, 8'hA5, "R5 direction unchanged");
      bus_read(A_DATA, 8'h3C, "R5 data unchanged");
      check8("R5 pin_oe unchanged", pin_oe, 8'hA5);
      check8("R5 pin_out unchanged", pin_out, 8'h3C);
      bus_read(A_NONE, 8'h00, "R5 unmapped read");

      // R6: no read request gives zero data
      @(negedge clk);
      check8("R6 idle rdata", bus_rdata, 8'h00);

      // R7: SPI owns pins 4..7
      bus_write(A_DIR, 8'h00);
      @(negedge clk); spi_en = 1'b1; spi_dir = 4'b1010;
      #1 check8("R7 spi dir 1010 over dir 00", pin_oe, 8'hA0);
      bus_write(A_DIR, 8'hFF);
      @(negedge clk); spi_dir = 4'b0000;
      #1 check8("R7 spi dir 0000 over dir FF", pin_oe, 8'h0F);
      bus_read(A_DIR, 8'hFF, "R7 direction retained");

      // R8 / R9: serial channel forcing, written while overridden
      bus_write(A_DIR, 8'h00);
      @(negedge clk); sci_tx_en = 1'b1;
      #1 check8("R8 tx forces pin1 out", pin_oe, 8'h02);
      @(negedge clk); sci_tx_en = 1'b0; sci_rx_en = 1'b1;
      bus_write(A_DIR, 8'hFF);
      #1 check8("R9 rx forces pin0 in", pin_oe, 8'h0E);
      @(negedge clk); sci_tx_en = 1'b1;
      bus_write(A_DIR, 8'h00);
      #1 check8("R8 R9 both serial over dir 00", pin_oe, 8'h02);
      bus_write(A_DIR, 8'h6D);
      bus_read(A_DIR, 8'h6D, "R10 direction retained under override");

      // R10: drop all enables, direction bits regain control
      @(negedge clk); spi_en = 1'b0; sci_tx_en = 1'b0; sci_rx_en = 1'b0;
      #1 check8("R10 revert to dir", pin_oe, 8'h6D);
      @(negedge clk); spi_en = 1'b1; spi_dir = 4'b1111;
      #1 check8("R7 spi again", pin_oe, 8'hFD);
      @(negedge clk); spi_en = 1'b0;
      #1 check8("R10 revert after spi", pin_oe, 8'h6D);

      // R11: synchronizer timing with back-to-back reads
      @(negedge clk);
      pin_in = 8'h96; bus_addr = A_IN; bus_rd = 1'b1;
      exp_q.push_back(8'hC3); tag_q.push_back("R11 read at edge A old");
      @(negedge clk);
      exp_q.push_back(8'hC3); tag_q.push_back("R11 read at edge A+1 old");
      @(negedge clk);
      exp_q.push_back(8'h96); tag_q.push_back("R11 read at edge A+2 new");
      @(negedge clk);
      bus_rd = 1'b0;

      repeat (4) @(negedge clk);
      if (exp_q.size() != 0) begin
         checks++; failures++;
         $display("FAIL R6 pending reads actual=%0d expected=0", exp_q.size());
      end
      summary();
      $finish;
   end

endmodule